// File: doc/BRIEF.md
# Completion Response Queue with Two-Word Read Window

This block stores one record for every descriptor the transfer engine finishes. Each record holds the byte count moved and a status word. The status word carries an 8-bit error code and a flag that marks early termination. Software reads the oldest record through a read window of two 32-bit words. It reads the byte count first and the status second. Only that second read, taken after the first, retires the record. A partial or repeated read therefore never loses a completion.

The block exports a 16-bit fill level, so an interrupt handler knows how many records to drain. It also exports empty and full flags for a status register, and a pending output that an interrupt controller can use. A completion that arrives while every slot is taken is discarded. The discard sets a sticky lost flag that only reset clears. Records leave in the same order they arrived. The depth is a parameter.

Top module: `rspq_readout`

## Requirements
- R1: After synchronous reset, `win_data` is zero, the fill level is zero, `rsp_empty` is 1, and `rsp_full`, `rsp_lost` and `rsp_pending` are 0.
- R2: A read with `win_word`=0 (offset 0x00) on a non-empty queue returns the byte count of the oldest record on `win_data` from the next cycle on. `win_data` holds that value until the next read.
- R3: A read with `win_word`=1 (offset 0x04) returns the status of the oldest record. Bits 7:0 hold the error code, bit 8 is the early-termination flag and bits 31:9 are zero.
- R4: A record is removed only by a `win_word`=1 read that follows at least one `win_word`=0 read of that same record. A `win_word`=0 read never removes a record.
- R5: A `win_word`=1 read of a record whose byte count has not yet been read returns its status and leaves the record and the fill level unchanged.
- R6: Any read while the queue is empty returns zero and changes neither the fill level nor the read window state.
- R7: Records are returned in the order their completions arrived.
- R8: `fill_word` bits 15:0 give the number of stored records and bits 31:16 are zero.
- R9: `rsp_empty` is 1 exactly when the fill level is 0, `rsp_full` is 1 exactly when it equals DEPTH, and `rsp_pending` is the inverse of `rsp_empty`.
- R10: A completion presented while `rsp_full` is 1 is discarded, even if a retiring read happens in the same cycle. The discard sets `rsp_lost`, which stays set until reset.
- R11: When a completion is accepted in the same cycle that a read retires a record, the fill level is unchanged and the new record lands behind the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpl_valid | input | 1 | One completion is presented this cycle |
| cpl_bytes | input | 32 | Bytes moved by the completed descriptor |
| cpl_err | input | 8 | Error code of the completed descriptor |
| cpl_early | input | 1 | Descriptor ended before its programmed length |
| win_rd | input | 1 | Read strobe for the window |
| win_word | input | 1 | Window word: 0 is offset 0x00 (bytes), 1 is offset 0x04 (status) |
| win_data | output | 32 | Registered read data of the window |
| fill_word | output | 32 | Fill level in bits 15:0, upper bits zero |
| rsp_empty | output | 1 | No record stored |
| rsp_full | output | 1 | All DEPTH slots occupied |
| rsp_lost | output | 1 | Sticky: a completion was discarded |
| rsp_pending | output | 1 | At least one record waits to be read |

## Verification
The hardest case to reach is a full queue that receives a completion in the same cycle that a read retires a record. To get there, the stimulus fills all DEPTH slots, reads the byte count of the head record, and then issues the status read together with a new completion. The bench then expects the fill level to drop by one and the lost flag to rise. A second hard case is a status read that arrives before the byte-count read. The stimulus issues it on a fresh head record, and again right after a retire, to show that the half-read state does not carry over to the next record.

// File: rtl/rspq_pkg.sv
package rspq_pkg;
  localparam int BYTES_W = 32;
  localparam int ERR_W   = 8;
  localparam int LVL_W   = 16;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic             early;
    logic [ERR_W-1:0] err;
    logic [BYTES_W-1:0] bytes;
  } rspq_entry_t;
endpackage

// File: rtl/rspq_ctrl.sv
module rspq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop,
  output logic          push_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          lost
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // fullness is judged on the registered level only; a retire in the same cycle does not make room
  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign push_ok = push_req && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      lost   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      level <= level + CW'(push_ok) - CW'(pop);
      if (push_req && full) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/rspq_mem.sv
module rspq_mem
  import rspq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rspq_entry_t   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output rspq_entry_t   rdata
);
  rspq_entry_t store [DEPTH];

  // one write port, one registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rspq_window.sv
module rspq_window (
  input  logic clk,
  input  logic rst,
  input  logic rd,
  input  logic word,
  input  logic empty,
  output logic pop,
  output logic sel_q,
  output logic zero_q
);
  logic bytes_seen;

  // retire only after the byte count of this head record has been read
  assign pop = rd && word && bytes_seen && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      bytes_seen <= 1'b0;
      sel_q      <= 1'b0;
      zero_q     <= 1'b1;
    end else if (rd) begin
      sel_q  <= word;
      zero_q <= empty;
      if (!empty) begin
        if (!word)          bytes_seen <= 1'b1;
        else if (bytes_seen) bytes_seen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rspq_readout.sv
module rspq_readout
  import rspq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpl_valid,
  input  logic [BYTES_W-1:0] cpl_bytes,
  input  logic [ERR_W-1:0]  cpl_err,
  input  logic              cpl_early,
  input  logic              win_rd,
  input  logic              win_word,
  output logic [WORD_W-1:0] win_data,
  output logic [WORD_W-1:0] fill_word,
  output logic              rsp_empty,
  output logic              rsp_full,
  output logic              rsp_lost,
  output logic              rsp_pending
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int STAT_PAD = WORD_W - ERR_W - 1;

  logic          push_ok, pop, sel_q, zero_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  rspq_entry_t   in_entry, head_q;

  assign in_entry = '{early: cpl_early, err: cpl_err, bytes: cpl_bytes};

  rspq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(cpl_valid), .pop(pop), .push_ok(push_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level),
    .empty(rsp_empty), .full(rsp_full), .lost(rsp_lost)
  );

  rspq_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(in_entry),
    .re(win_rd), .raddr(rd_ptr), .rdata(head_q)
  );

  rspq_window u_win (
    .clk(clk), .rst(rst), .rd(win_rd), .word(win_word), .empty(rsp_empty),
    .pop(pop), .sel_q(sel_q), .zero_q(zero_q)
  );

  always_comb begin
    if (zero_q)     win_data = '0;
    else if (sel_q) win_data = {{STAT_PAD{1'b0}}, head_q.early, head_q.err};
    else            win_data = WORD_W'(head_q.bytes);
  end

  assign fill_word   = WORD_W'(LVL_W'(level));
  assign rsp_pending = !rsp_empty;
endmodule

// File: rtl/rspq_chk.sv
module rspq_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        cpl_valid,
  input logic        win_rd,
  input logic        win_word,
  input logic [31:0] win_data,
  input logic [31:0] fill_word,
  input logic        rsp_empty,
  input logic        rsp_full,
  input logic        rsp_lost,
  input logic        rsp_pending
);
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (win_rd && rsp_empty && !cpl_valid) |=> (win_data == 32'd0 && $stable(fill_word)));

  a_r4_word0_no_retire: assert property (@(posedge clk) disable iff (rst)
    (win_rd && !win_word && !cpl_valid) |=> $stable(fill_word));

  a_r3_status_pad: assert property (@(posedge clk) disable iff (rst)
    (win_rd && win_word) |=> (win_data[31:9] == 23'd0));

  a_r8_level_pad: assert property (@(posedge clk) disable iff (rst)
    fill_word[31:16] == 16'd0);

  a_r9_empty_flag: assert property (@(posedge clk) disable iff (rst)
    rsp_empty == (fill_word == 32'd0));

  a_r9_full_flag: assert property (@(posedge clk) disable iff (rst)
    rsp_full == (fill_word == 32'(DEPTH)));

  a_r9_pending: assert property (@(posedge clk) disable iff (rst)
    rsp_pending != rsp_empty);

  a_r10_lost_sticky: assert property (@(posedge clk) disable iff (rst)
    rsp_lost |=> rsp_lost);

  a_r10_lost_set: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && rsp_full) |=> rsp_lost);

  a_r10_full_drop: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && rsp_full && !win_rd) |=> $stable(fill_word));
endmodule

bind rspq_readout rspq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cpl_valid(cpl_valid), .win_rd(win_rd), .win_word(win_word),
  .win_data(win_data), .fill_word(fill_word), .rsp_empty(rsp_empty),
  .rsp_full(rsp_full), .rsp_lost(rsp_lost), .rsp_pending(rsp_pending)
);

// File: tb/rspq_readout_tb.sv
module rspq_readout_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_bytes = '0;
  logic [7:0]  cpl_err = '0;
  logic        cpl_early = 1'b0;
  logic        win_rd = 1'b0;
  logic        win_word = 1'b0;
  logic [31:0] win_data, fill_word;
  logic        rsp_empty, rsp_full, rsp_lost, rsp_pending;

  always #4 clk = ~clk;

  rspq_readout #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cpl_valid(cpl_valid), .cpl_bytes(cpl_bytes),
    .cpl_err(cpl_err), .cpl_early(cpl_early), .win_rd(win_rd), .win_word(win_word),
    .win_data(win_data), .fill_word(fill_word), .rsp_empty(rsp_empty),
    .rsp_full(rsp_full), .rsp_lost(rsp_lost), .rsp_pending(rsp_pending)
  );

  typedef struct { logic [31:0] b; logic [7:0] e; logic x; } rec_t;
  rec_t   mq[$];
  logic   m_seen = 1'b0;
  logic   m_lost = 1'b0;
  logic [31:0] m_data = '0;
  int     n_chk = 0;
  int     n_fail = 0;
  bit     chk_on = 1'b0;
  string  tag = "R1";

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_seen = 1'b0; m_lost = 1'b0; m_data = '0;
    end else begin
      automatic bit was_empty = (mq.size() == 0);
      automatic bit was_full  = (mq.size() == DEPTH);
      automatic bit retire    = 1'b0;
      if (win_rd) begin
        if (was_empty) m_data = '0;
        else if (!win_word) begin m_data = mq[0].b; m_seen = 1'b1; end
        else begin
          m_data = {23'd0, mq[0].x, mq[0].e};
          if (m_seen) retire = 1'b1;
        end
      end
      if (retire) begin void'(mq.pop_front()); m_seen = 1'b0; end
      if (cpl_valid) begin
        if (was_full) m_lost = 1'b1;
        else mq.push_back('{b: cpl_bytes, e: cpl_err, x: cpl_early});
      end
    end
  end

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(tag, "win_data", win_data, m_data);
      chk("R8", "fill_word", fill_word, 32'(mq.size()));
      chk("R9", "rsp_empty", 32'(rsp_empty), 32'(mq.size() == 0));
      chk("R9", "rsp_full", 32'(rsp_full), 32'(mq.size() == DEPTH));
      chk("R9", "rsp_pending", 32'(rsp_pending), 32'(mq.size() != 0));
      chk("R10", "rsp_lost", 32'(rsp_lost), 32'(m_lost));
    end
  end

  task automatic op(bit cv, logic [31:0] b, logic [7:0] e, bit x, bit rd, bit w);
    cpl_valid = cv; cpl_bytes = b; cpl_err = e; cpl_early = x;
    win_rd = rd; win_word = w;
    @(posedge clk); #1;
    cpl_valid = 1'b0; win_rd = 1'b0;
  endtask

  task automatic push(logic [31:0] b, logic [7:0] e, bit x);
    op(1'b1, b, e, x, 1'b0, 1'b0);
  endtask

  task automatic rd(bit w);
    op(1'b0, '0, '0, 1'b0, 1'b1, w);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    chk("R1", "win_data", win_data, 32'd0);
    chk("R1", "fill_word", fill_word, 32'd0);
    chk("R1", "flags", {28'd0, rsp_empty, rsp_full, rsp_lost, rsp_pending}, 32'h8);
    chk_on = 1'b1;
    @(posedge clk); #1;

    tag = "R6";
    rd(1'b0); rd(1'b1); rd(1'b1);

    tag = "R2";
    push(32'h0000_1000, 8'h00, 1'b0);
    push(32'h0000_0040, 8'h5a, 1'b1);
    push(32'h0bad_0003, 8'hff, 1'b0);
    tag = "R5";
    rd(1'b1); rd(1'b1);
    tag = "R2";
    rd(1'b0); rd(1'b0);
    tag = "R3";
    rd(1'b1);
    tag = "R5";
    rd(1'b1);
    tag = "R3";
    rd(1'b0); rd(1'b1);
    tag = "R7";
    rd(1'b0); rd(1'b1);
    tag = "R6";
    rd(1'b1); rd(1'b0);

    tag = "R11";
    push(32'd11, 8'd1, 1'b0);
    push(32'd22, 8'd2, 1'b1);
    rd(1'b0);
    op(1'b1, 32'd33, 8'd3, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) begin rd(1'b0); rd(1'b1); end

    tag = "R10";
    for (int i = 0; i < DEPTH + 2; i++) push(32'(i * 7 + 1), 8'(i), i[0]);
    rd(1'b0);
    op(1'b1, 32'hdead_beef, 8'h77, 1'b1, 1'b1, 1'b1);
    tag = "R7";
    for (int i = 0; i < DEPTH; i++) begin rd(1'b0); rd(1'b1); end

    tag = "R7";
    for (int i = 0; i < 600; i++)
      op(($urandom_range(0, 2) == 0), $urandom(), 8'($urandom()), 1'($urandom()),
         ($urandom_range(0, 1) == 1), 1'($urandom()));

    @(negedge clk);
    chk_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule